// File: doc/BRIEF.md
# E1 Sa-bit transmit inserter

This block keeps five 8-bit national-bit registers, one for each of the Sa4 to Sa8 positions of timeslot 0 in an E1 transmit stream. Software writes the registers through a plain address/data port and can read them back. The transmit framer supplies the current frame number inside the 16-frame CRC-4 multiframe, together with a one-cycle strobe at the start of each multiframe.

On that strobe the block copies all 40 register bits into a shadow bank at once. During the odd frames that follow, it presents one bit per Sa position per frame on a 5-bit output and raises a valid flag. Frame 2n+1 carries bit n of every register. Because the copy is taken once per multiframe, software has a whole multiframe after each boundary to load the values for the next one. The Sa bits therefore always stay aligned with the CRC-4 multiframe.

Top module: `e1_sa_tx`

## Requirements
- R1: Five 8-bit registers sit at offsets 0 to 4 (offset 0 is Sa4, offset 4 is Sa8). Each can be written and read back, and each resets to 0xFF.
- R2: Offsets 5 to 7 always read 0x00. A write to them changes none of the five registers.
- R3: On a clock edge where `mf_start_i` is high, all five registers are copied into the shadow bank together.
- R4: Between two multiframe strobes the shadow bank does not change. A register write made during a multiframe does not alter the Sa output until the next strobe.
- R5: In odd frame 2n+1 (n = 0..7), `sa_valid_o` is 1 and `sa_bits_o[k]` equals bit n of the shadow copy of register k (bit 0 of the output is Sa4, bit 4 is Sa8).
- R6: In even frames (`frame_num_i[0]` = 0), `sa_valid_o` is 0 and `sa_bits_o` is 0.
- R7: A write in the same cycle as `mf_start_i` updates the live register, but the shadow takes the value from before the write. The new value goes out only after the next strobe.
- R8: From reset until the first strobe, the shadow bank holds all ones, so odd frames output 5'b11111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 3 | Write offset |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 3 | Read offset |
| rd_data_o | output | 8 | Read data (combinational) |
| mf_start_i | input | 1 | One-cycle strobe at frame 0 of each multiframe |
| frame_num_i | input | 4 | Current frame number, 0 to 15 |
| sa_bits_o | output | 5 | Sa4..Sa8 bits for the current frame |
| sa_valid_o | output | 1 | High in odd frames, when Sa bits are carried |

## Verification
The bench sweeps every frame of several multiframes and checks each of the 40 bit positions against a model of the shadow bank. A bit-order or frame-to-bit mapping error shows up as a wrong bit in a specific frame. A shadow that follows the live registers is caught by writes made in frame 3, which would appear in later frames of the same multiframe. The bench also writes in the strobe cycle itself: a design that lets that write into the shadow would send the new value one multiframe early. Finally, writes to the unused offsets are followed by a full readback, and the odd frames before the first strobe are checked for all ones, which catches a corrupted register or a shadow reset to zero.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int unsigned NUM_SA  = 5;
  localparam int unsigned SA_W    = 8;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned FRAME_W = 4;
  localparam logic [SA_W-1:0] SA_IDLE = '1;
endpackage

// File: rtl/sa_regfile.sv
module sa_regfile #(
  parameter int unsigned N  = 5,
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [W-1:0]        wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [W-1:0]        rd_data_o,
  output logic [N-1:0][W-1:0] regs_o
);
  for (genvar k = 0; k < N; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[k] <= RST_VAL;
      else if (wr_en_i && wr_addr_i == AW'(k)) regs_o[k] <= wr_data_i;
    end

    p_write_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == AW'(k)) |=> regs_o[k] == $past(wr_data_i));
    p_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i >= AW'(N)) |=> $stable(regs_o[k]));
  end

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < N; k++)
      if (rd_addr_i == AW'(k)) rd_data_o = regs_o[k];
  end
endmodule

// File: rtl/sa_shadow.sv
module sa_shadow #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 8,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic [N-1:0][W-1:0] live_i,
  output logic [N-1:0][W-1:0] shadow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shadow_o <= {N{RST_VAL}};
    else if (capture_i) shadow_o <= live_i;
  end

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |=> shadow_o == $past(live_i));
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(shadow_o));
endmodule

// File: rtl/sa_bit_sel.sv
module sa_bit_sel #(
  parameter int unsigned N  = 5,
  parameter int unsigned W  = 8,
  parameter int unsigned FW = 4
) (
  input  logic [N-1:0][W-1:0] shadow_i,
  input  logic [FW-1:0]       frame_i,
  output logic [N-1:0]        bits_o,
  output logic                valid_o
);
  localparam int unsigned SEL_W = FW - 1;
  logic [SEL_W-1:0] sel;
  logic             odd;

  assign odd = frame_i[0];
  assign sel = frame_i[FW-1:1];   // frame 2n+1 -> bit n
  assign valid_o = odd;

  for (genvar k = 0; k < N; k++) begin : g_pos
    assign bits_o[k] = odd & shadow_i[k][sel];
  end
endmodule

// File: rtl/e1_sa_tx.sv
module e1_sa_tx
  import e1_sa_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [SA_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [SA_W-1:0]    rd_data_o,
  input  logic               mf_start_i,
  input  logic [FRAME_W-1:0] frame_num_i,
  output logic [NUM_SA-1:0]  sa_bits_o,
  output logic               sa_valid_o
);
  logic [NUM_SA-1:0][SA_W-1:0] live_q;
  logic [NUM_SA-1:0][SA_W-1:0] shadow_q;

  sa_regfile #(.N(NUM_SA), .W(SA_W), .AW(ADDR_W), .RST_VAL(SA_IDLE)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i, .rd_data_o, .regs_o(live_q)
  );

  sa_shadow #(.N(NUM_SA), .W(SA_W), .RST_VAL(SA_IDLE)) u_shadow (
    .clk_i, .rst_ni, .capture_i(mf_start_i), .live_i(live_q), .shadow_o(shadow_q)
  );

  sa_bit_sel #(.N(NUM_SA), .W(SA_W), .FW(FRAME_W)) u_sel (
    .shadow_i(shadow_q), .frame_i(frame_num_i), .bits_o(sa_bits_o), .valid_o(sa_valid_o)
  );

  p_reserved_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_addr_i >= ADDR_W'(NUM_SA) |-> rd_data_o == '0);
  p_even_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_num_i[0] |-> (!sa_valid_o && sa_bits_o == '0));
  p_odd_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_num_i[0] |-> sa_valid_o);
  p_strobe_frame0_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mf_start_i |-> frame_num_i == '0);
endmodule

// File: tb/sim_e1_sa_tx.sv
module sim_e1_sa_tx;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       wr_en = 0;
  logic [2:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] rd_addr = 0;
  logic [7:0] rd_data;
  logic       mf_start = 0;
  logic [3:0] frame = 0;
  logic [4:0] sa_bits;
  logic       sa_valid;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] live_m [5];
  logic [7:0] shad_m [5];

  always #10 clk = ~clk;

  e1_sa_tx u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .mf_start_i(mf_start), .frame_num_i(frame), .sa_bits_o(sa_bits),
    .sa_valid_o(sa_valid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 0;
    if (a < 5) live_m[a] = d;
  endtask

  task automatic check_reads(input string req);
    for (int k = 0; k < 8; k++) begin
      rd_addr = 3'(k);
      #1;
      check(rd_data == ((k < 5) ? live_m[k] : 8'h00), req, rd_data,
            (k < 5) ? live_m[k] : 0);
    end
  endtask

  // R5/R6 check of one frame against shad_m
  task automatic check_frame(input int f, input string req);
    logic [4:0] exp_bits;
    #5;
    exp_bits = '0;
    if (f % 2 == 1)
      for (int k = 0; k < 5; k++) exp_bits[k] = shad_m[k][f >> 1];
    check(sa_valid == (f % 2 == 1), {req, " valid"}, sa_valid, f % 2);
    check(sa_bits == exp_bits, req, sa_bits, exp_bits);
  endtask

  task automatic run_mf(input bit race, input bit mid, input int seed);
    logic [7:0] rv;
    int ra;
    frame = 0; mf_start = 1;
    for (int k = 0; k < 5; k++) shad_m[k] = live_m[k];
    ra = seed % 5;
    rv = 8'((seed * 53) ^ 8'hC3);
    if (race) begin
      wr_en = 1; wr_addr = 3'(ra); wr_data = rv;
    end
    check_frame(0, "R6");
    tick();
    mf_start = 0; wr_en = 0;
    if (race) live_m[ra] = rv;   // R7: live updated, shadow kept old value
    for (int f = 1; f < 16; f++) begin
      frame = 4'(f);
      if (mid && f == 3) begin
        wr_en = 1; wr_addr = 3'((seed + 2) % 5); wr_data = ~shad_m[(seed + 2) % 5];
      end
      check_frame(f, race ? "R7" : (mid ? "R4" : "R5"));
      tick();
      if (wr_en) begin
        live_m[wr_addr] = wr_data;
        wr_en = 0;
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 5; k++) begin live_m[k] = 8'hFF; shad_m[k] = 8'hFF; end
    #25 rst_n = 1;
    @(negedge clk);
    check_reads("R1");  // reset value 0xFF
    // R8: pre-strobe shadow is all ones, also after writes
    for (int k = 0; k < 5; k++) do_write(3'(k), 8'(k * 29 + 7));
    for (int f = 0; f < 16; f++) begin
      frame = 4'(f);
      check_frame(f, "R8");
      tick();
    end
    check_reads("R1");
    // R2: unused offsets
    for (int a = 5; a < 8; a++) do_write(3'(a), 8'h00);
    check_reads("R2");
    // R3/R5 sweeps over several patterns
    run_mf(0, 0, 0);
    for (int p = 1; p < 6; p++) begin
      for (int k = 0; k < 5; k++) do_write(3'(k), 8'((k * 37 + p * 91) ^ 8'h5A));
      run_mf(0, 0, p);
    end
    for (int k = 0; k < 5; k++) do_write(3'(k), 8'(1 << k));
    run_mf(0, 0, 7);
    // R4: write during frame 3 must wait
    run_mf(0, 1, 3);
    run_mf(0, 0, 4);
    // R7: write coincident with strobe
    run_mf(1, 0, 9);
    check_reads("R7");
    run_mf(0, 0, 10);
    run_mf(1, 1, 12);
    run_mf(0, 0, 13);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule